// File: doc/BRIEF.md
# Panel Controller Register and Interrupt Unit

This unit is the software-visible register file of a simple display panel controller. A 32-bit bus with byte offsets writes and reads six words: a control word, a horizontal and a vertical timing word (each holding a panel dimension minus one in its low ten bits), a raw auxiliary timing word, a read-only status word and a subpanel word. Several words read back with fixed constant bits ORed in, as the surrounding software expects.

A pixel fetch engine beside the unit sends single-cycle event pulses for frame done, palette loaded and synchronisation error. Each pulse sets a sticky status flag. Edges of the enable bit also update the flags: switching the controller off clears the error flag and reports a finished frame, and switching it on clears the frame and palette flags. The unit merges the flags into one level-sensitive interrupt line. Two of the flags can be masked. The error flag cannot be masked.

Top module: `panel_ctl_regs`

## Requirements
- R1: After reset every stored field, both dimensions and all three flags are zero, so the control, horizontal-timing, auxiliary-timing reads return only their fixed constants, the other reads return zero, and irq is low.
- R2: A write to offset 0x00 stores mode from bits 21:20, tft from bit 7, a two-bit interrupt mask from bits 4:3, mono from bit 1 and enable from bit 0, plus the written value ANDed with 0x01cff300. A read of 0x00 returns that retained value ORed with tft at bits 23 and 7, mode at 21:20, mask at 4:3, mono at 1, enable at 0 and the constant 0xfe000c34.
- R3: A write to offset 0x04 or 0x08 stores bits 9:0 as the dimension minus one and bits 31:10 separately. A read returns both parts in their places, and the 0x04 read also ORs in 0x0000000f.
- R4: Offset 0x0c stores the whole written word and reads it back ORed with 0xfc000000.
- R5: A write to offset 0x14 stores the value ANDed with 0xa1ffffff, and a read returns the stored value.
- R6: Offset 0x10 reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. Each event pulse sets its flag, and the flag stays set. A write to 0x10 changes nothing.
- R7: irq is high exactly when (frame-done and mask bit 0), or (palette-done and mask bit 1), or sync-error holds. Mask bit 0 is written bit 3, and mask bit 1 is written bit 4.
- R8: A control write that changes enable from 1 to 0 clears sync-error. It also sets frame-done unless the mode written in that same word is 1.
- R9: A control write that changes enable from 0 to 1 clears frame-done and palette-done. A control write that leaves enable unchanged does not touch the flags.
- R10: An event pulse in the same cycle as an enable edge wins over that edge's clearing of frame-done or palette-done. A disable edge clears sync-error even if a sync-error pulse arrives in the same cycle.
- R11: A read of any offset other than 0x00, 0x04, 0x08, 0x0c, 0x10 or 0x14 returns zero. This includes unaligned offsets. A write to such an offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_frame | input | 1 | Frame-done event pulse |
| ev_palette | input | 1 | Palette-loaded event pulse |
| ev_sync | input | 1 | Synchronisation-error event pulse |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the enable edges. If the unit mistook a rewrite of the same enable value for an edge, the flags would clear when they should not. If it took the mode from the old control value instead of the word being written, it would report frame-done wrongly on a disable in mode 1. Collisions between an event pulse and an edge come next: the wrong priority either loses a frame-done that arrived with the enable, or leaves a sync error standing after the disable. Readback patterns are chosen so that retained bits overlap the constant bits and the field bits, which exposes a wrong mask or a missing OR. Writes to the status offset and to undefined or unaligned offsets must leave every readable word unchanged.

// File: rtl/panel_ctl_pkg.sv
package panel_ctl_pkg;
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_HTIM = 'h04;
  localparam int unsigned OFS_VTIM = 'h08;
  localparam int unsigned OFS_AUX  = 'h0c;
  localparam int unsigned OFS_STAT = 'h10;
  localparam int unsigned OFS_SUB  = 'h14;

  localparam logic [31:0] CTRL_KEEP  = 32'h01cf_f300;
  localparam logic [31:0] CTRL_FIXED = 32'hfe00_0c34;
  localparam logic [31:0] HTIM_FIXED = 32'h0000_000f;
  localparam logic [31:0] AUX_FIXED  = 32'hfc00_0000;
  localparam logic [31:0] SUB_KEEP   = 32'ha1ff_ffff;

  typedef struct packed {
    logic [1:0] mode;
    logic       tft;
    logic [1:0] irq_mask;
    logic       mono;
    logic       en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(logic [31:0] w);
    ctrl_t c;
    c.mode     = w[21:20];
    c.tft      = w[7];
    c.irq_mask = w[4:3];
    c.mono     = w[1];
    c.en       = w[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(ctrl_t c, logic [31:0] kept);
    logic [31:0] w;
    w         = kept | CTRL_FIXED;
    w[23]     = w[23] | c.tft;
    w[21:20]  = w[21:20] | c.mode;
    w[7]      = w[7] | c.tft;
    w[4:3]    = w[4:3] | c.irq_mask;
    w[1]      = w[1] | c.mono;
    w[0]      = w[0] | c.en;
    return w;
  endfunction

  function automatic logic [31:0] status_word(logic frame, logic pal, logic sync);
    logic [31:0] w;
    w    = '0;
    w[6] = pal;
    w[2] = sync;
    w[0] = frame;
    return w;
  endfunction
endpackage

// File: rtl/panel_ctl_dimreg.sv
module panel_ctl_dimreg #(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word
);
  localparam int HI_W = DATA_W - DIM_W;

  logic [DIM_W-1:0] dim_m1_q;
  logic [HI_W-1:0]  upper_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dim_m1_q <= '0;
      upper_q  <= '0;
    end else if (we) begin
      dim_m1_q <= wdata[DIM_W-1:0];
      upper_q  <= wdata[DATA_W-1:DIM_W];
    end
  end

  assign word = {upper_q, dim_m1_q};

  AST_DIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(word)); // R3
endmodule

// File: rtl/panel_ctl_flags.sv
module panel_ctl_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic       fall_mode_one,
  input  logic       ev_frame,
  input  logic       ev_palette,
  input  logic       ev_sync,
  input  logic [1:0] irq_mask,
  output logic       frame_q,
  output logic       pal_q,
  output logic       sync_q,
  output logic       irq
);
  logic fall_reports_frame;
  assign fall_reports_frame = en_fall & ~fall_mode_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= 1'b0;
      pal_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      frame_q <= ev_frame | fall_reports_frame | (frame_q & ~en_rise);
      pal_q   <= ev_palette | (pal_q & ~en_rise);
      sync_q  <= ~en_fall & (ev_sync | sync_q);
    end
  end

  assign irq = (frame_q & irq_mask[0]) | (pal_q & irq_mask[1]) | sync_q;

  AST_FALL_CLEARS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !sync_q); // R8
  AST_FALL_REPORTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !fall_mode_one) |=> frame_q); // R8
  AST_RISE_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rise && !ev_frame && !ev_palette) |=> (!frame_q && !pal_q)); // R9
  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_palette |=> pal_q); // R6
  AST_SYNC_UNMASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sync && !en_fall) |=> irq); // R7
endmodule

// File: rtl/panel_ctl_regs.sv
module panel_ctl_regs
  import panel_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_frame,
  input  logic              ev_palette,
  input  logic              ev_sync,
  output logic              irq
);
  localparam int NUM_DIM = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_HTIM = ADDR_W'(OFS_HTIM);
  localparam logic [ADDR_W-1:0] A_VTIM = ADDR_W'(OFS_VTIM);
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(OFS_AUX);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SUB  = ADDR_W'(OFS_SUB);

  ctrl_t       ctrl_q, ctrl_wr;
  logic [31:0] kept_q, aux_q, sub_q;
  logic        wr_ctrl, wr_aux, wr_sub, wr_stat;
  logic        en_rise, en_fall;
  logic        frame_q, pal_q, sync_q;
  logic [31:0] dim_word [NUM_DIM];

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_aux  = bus_wr && (bus_addr == A_AUX);
  assign wr_sub  = bus_wr && (bus_addr == A_SUB);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign ctrl_wr = ctrl_from_word(bus_wdata);
  assign en_rise = wr_ctrl && ctrl_wr.en && !ctrl_q.en;
  assign en_fall = wr_ctrl && !ctrl_wr.en && ctrl_q.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      kept_q <= '0;
      aux_q  <= '0;
      sub_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_wr;
        kept_q <= bus_wdata & CTRL_KEEP;
      end
      if (wr_aux) aux_q <= bus_wdata;
      if (wr_sub) sub_q <= bus_wdata & SUB_KEEP;
    end
  end

  for (genvar g = 0; g < NUM_DIM; g++) begin : g_dim
    localparam logic [ADDR_W-1:0] A_DIM = (g == 0) ? A_HTIM : A_VTIM;
    panel_ctl_dimreg #(.DATA_W(32), .DIM_W(DIM_W)) dim_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr && (bus_addr == A_DIM)),
      .wdata (bus_wdata),
      .word  (dim_word[g])
    );
  end

  panel_ctl_flags flags_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_rise       (en_rise),
    .en_fall       (en_fall),
    .fall_mode_one (ctrl_wr.mode == 2'd1),
    .ev_frame      (ev_frame),
    .ev_palette    (ev_palette),
    .ev_sync       (ev_sync),
    .irq_mask      (ctrl_q.irq_mask),
    .frame_q       (frame_q),
    .pal_q         (pal_q),
    .sync_q        (sync_q),
    .irq           (irq)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_to_word(ctrl_q, kept_q);
      A_HTIM:  bus_rdata = dim_word[0] | HTIM_FIXED;
      A_VTIM:  bus_rdata = dim_word[1];
      A_AUX:   bus_rdata = aux_q | AUX_FIXED;
      A_STAT:  bus_rdata = status_word(frame_q, pal_q, sync_q);
      A_SUB:   bus_rdata = sub_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !ev_frame && !ev_palette && !ev_sync)
      |=> ($stable(frame_q) && $stable(pal_q) && $stable(sync_q))); // R6
  AST_SAME_EN_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && (ctrl_wr.en == ctrl_q.en)) |-> (!en_rise && !en_fall)); // R9
  AST_SUB_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sub |=> ((sub_q & ~SUB_KEEP) == 32'h0)); // R5
endmodule

// File: tb/panel_ctl_regs_tb_top.sv
module panel_ctl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_frame = 1'b0, ev_palette = 1'b0, ev_sync = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model, built from the requirements
  logic [1:0]  m_mode;
  logic        m_tft, m_mono, m_en;
  logic [1:0]  m_mask;
  logic [31:0] m_kept, m_h, m_v, m_aux, m_sub;
  logic        m_fr, m_pal, m_syn;

  always #2 clk = ~clk;

  panel_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_frame(ev_frame),
    .ev_palette(ev_palette), .ev_sync(ev_sync), .irq(irq)
  );

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] w;
    case (a)
      8'h00: begin
        w = m_kept | 32'hfe000c34 | ({31'b0, m_tft} << 23) | ({30'b0, m_mode} << 20)
          | ({31'b0, m_tft} << 7) | ({30'b0, m_mask} << 3) | ({31'b0, m_mono} << 1)
          | {31'b0, m_en};
      end
      8'h04: w = m_h | 32'h0000000f;
      8'h08: w = m_v;
      8'h0c: w = m_aux | 32'hfc000000;
      8'h10: w = ({31'b0, m_pal} << 6) | ({31'b0, m_syn} << 2) | {31'b0, m_fr};
      8'h14: w = m_sub;
      default: w = 32'h0;
    endcase
    return w;
  endfunction

  function automatic logic exp_irq();
    return (m_fr & m_mask[0]) | (m_pal & m_mask[1]) | m_syn;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic chk_rd(string req, logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, bus_rdata, exp_rd(a));
  endtask

  task automatic chk_all(string req);
    chk_rd(req, 8'h00); chk_rd(req, 8'h04); chk_rd(req, 8'h08);
    chk_rd(req, 8'h0c); chk_rd(req, 8'h10); chk_rd(req, 8'h14);
    chk({req, " irq"}, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  // one bus cycle, optional write, optional event pulses, model updated
  task automatic cyc(bit wr, logic [7:0] a, logic [31:0] d, bit f, bit p, bit s);
    logic rise, fall, fr_n, pal_n, syn_n;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    ev_frame = f; ev_palette = p; ev_sync = s;
    rise = 1'b0; fall = 1'b0;
    if (wr && a == 8'h00) begin
      rise = d[0] & ~m_en;
      fall = ~d[0] & m_en;
      m_mode = d[21:20]; m_tft = d[7]; m_mask = d[4:3]; m_mono = d[1]; m_en = d[0];
      m_kept = d & 32'h01cff300;
    end
    if (wr && a == 8'h04) m_h = d;
    if (wr && a == 8'h08) m_v = d;
    if (wr && a == 8'h0c) m_aux = d;
    if (wr && a == 8'h14) m_sub = d & 32'ha1ffffff;
    fr_n = m_fr; pal_n = m_pal; syn_n = m_syn;
    if (fall && m_mode != 2'd1) fr_n = 1'b1;
    if (rise) begin fr_n = 1'b0; pal_n = 1'b0; end
    if (f) fr_n = 1'b1;
    if (p) pal_n = 1'b1;
    if (s) syn_n = 1'b1;
    if (fall) syn_n = 1'b0;
    m_fr = fr_n; m_pal = pal_n; m_syn = syn_n;
    @(negedge clk);
    bus_wr = 1'b0; ev_frame = 1'b0; ev_palette = 1'b0; ev_sync = 1'b0;
  endtask

  task automatic t_reset();
    m_mode = 0; m_tft = 0; m_mono = 0; m_en = 0; m_mask = 0;
    m_kept = 0; m_h = 0; m_v = 0; m_aux = 0; m_sub = 0;
    m_fr = 0; m_pal = 0; m_syn = 0;
    chk_all("R1 reset");
  endtask

  task automatic t_ctrl();
    cyc(1, 8'h00, 32'h01cff300, 0, 0, 0);   // retained bits only, enable off
    chk_rd("R2 kept bits", 8'h00);
    cyc(1, 8'h00, 32'h0032_0082, 0, 0, 0);  // mode 3, tft, mono, enable off
    chk_rd("R2 fields", 8'h00);
    cyc(1, 8'h00, 32'h0010_0000, 0, 0, 0);  // mode 1 only
    chk_rd("R2 mode one", 8'h00);
  endtask

  task automatic t_words();
    cyc(1, 8'h04, 32'hABCD_E123, 0, 0, 0);
    cyc(1, 8'h08, 32'h1234_57FF, 0, 0, 0);
    cyc(1, 8'h0c, 32'h0123_4567, 0, 0, 0);
    cyc(1, 8'h14, 32'hFFFF_FFFF, 0, 0, 0);
    chk_rd("R3 horizontal", 8'h04);
    chk_rd("R3 vertical", 8'h08);
    chk_rd("R4 aux", 8'h0c);
    chk_rd("R5 subpanel", 8'h14);
    cyc(1, 8'h14, 32'h5E00_0001, 0, 0, 0);
    chk_rd("R5 subpanel mask", 8'h14);
  endtask

  task automatic t_status();
    cyc(0, 8'h00, 0, 0, 1, 0);
    chk_rd("R6 palette", 8'h10);
    cyc(0, 8'h00, 0, 1, 0, 0);
    cyc(0, 8'h00, 0, 0, 0, 0);
    chk_rd("R6 sticky", 8'h10);
    cyc(1, 8'h10, 32'hFFFF_FFFF, 0, 0, 0);
    chk_all("R6 status write ignored");
    cyc(1, 8'h10, 32'h0000_0000, 0, 0, 0);
    chk_rd("R6 status zero write ignored", 8'h10);
  endtask

  task automatic t_irq();
    // frame and palette set, enable off; vary mask with no enable change
    cyc(1, 8'h00, 32'h0000_0000, 0, 0, 0);
    chk({"R7 mask none"}, {31'b0, irq}, {31'b0, exp_irq()});
    cyc(1, 8'h00, 32'h0000_0008, 0, 0, 0);
    chk({"R7 mask frame"}, {31'b0, irq}, {31'b0, exp_irq()});
    cyc(1, 8'h00, 32'h0000_0001, 0, 0, 0);  // enable: clears both flags
    cyc(0, 8'h00, 0, 0, 1, 0);
    cyc(1, 8'h00, 32'h0000_0011, 0, 0, 0);
    chk({"R7 mask palette"}, {31'b0, irq}, {31'b0, exp_irq()});
    cyc(1, 8'h00, 32'h0000_0009, 0, 0, 0);
    chk({"R7 palette masked off"}, {31'b0, irq}, {31'b0, exp_irq()});
    cyc(1, 8'h00, 32'h0000_0001, 0, 0, 1);
    chk({"R7 sync unmaskable"}, {31'b0, irq}, {31'b0, exp_irq()});
  endtask

  task automatic t_edges();
    // currently enabled with sync and palette set
    cyc(1, 8'h00, 32'h0000_0000, 0, 0, 0);  // disable mode 0
    chk_rd("R8 disable mode 0", 8'h10);
    cyc(1, 8'h00, 32'h0000_0001, 0, 0, 0);  // enable clears
    chk_rd("R9 enable clears", 8'h10);
    cyc(0, 8'h00, 0, 0, 0, 1);
    cyc(1, 8'h00, 32'h0010_0000, 0, 0, 0);  // disable mode 1
    chk_rd("R8 disable mode 1", 8'h10);
    cyc(0, 8'h00, 0, 1, 1, 0);
    cyc(1, 8'h00, 32'h0000_0000, 0, 0, 0);  // same enable, no edge
    chk_rd("R9 no edge keeps flags", 8'h10);
  endtask

  task automatic t_priority();
    cyc(1, 8'h00, 32'h0000_0001, 1, 0, 0);  // rise with frame event
    chk_rd("R10 frame beats rise", 8'h10);
    cyc(1, 8'h00, 32'h0010_0000, 0, 0, 1);  // fall mode 1 with sync event
    chk_rd("R10 fall beats sync", 8'h10);
    cyc(1, 8'h00, 32'h0000_0001, 0, 1, 0);  // rise with palette event
    chk_rd("R10 palette beats rise", 8'h10);
  endtask

  task automatic t_undef();
    chk_rd("R11 read 0x18", 8'h18);
    chk_rd("R11 read 0x02", 8'h02);
    chk_rd("R11 read 0xfc", 8'hfc);
    cyc(1, 8'h18, 32'hFFFF_FFFF, 0, 0, 0);
    cyc(1, 8'h01, 32'h0000_0000, 0, 0, 0);
    cyc(1, 8'h06, 32'hFFFF_FFFF, 0, 0, 0);
    chk_all("R11 undefined writes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ctrl();
    t_words();
    t_status();
    t_irq();
    t_edges();
    t_priority();
    t_undef();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule